// File: doc/BRIEF.md
# Turnstile Access Controller

This block is the control state machine of a fare gate. It watches three active-high inputs: a valid fare card is presented, a passenger walks through the gate, and an alarm is cleared by staff. From these it drives one output that keeps the gate bolted. The controller has three conditions: bolted and waiting, released after a valid card, and an alarm condition that is entered when someone walks through while the gate is bolted. Once the alarm condition is entered, only the alarm clear input ends it.

The output is a Moore output. It depends only on the registered state and changes on the clock edge that changes the state. The state uses a two-bit code: bolted = 00, released = 01, alarm = 10. Code 11 is never entered, and if it were ever held it would return to bolted. The asynchronous active-low reset takes effect at once and is released through a synchronizer. A clock edge is therefore needed before the machine responds to its inputs.

Top module: `turnstile_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the machine is bolted and `gate_locked` reads 1.
- R2: When bolted with `alarm_clr`=0, the pair (`walk_thru`,`card_ok`)=00 or 11 keeps it bolted. 01 releases it. 10 enters the alarm condition.
- R3: When released with `alarm_clr`=0, a walk without a card (10) bolts the gate. Every other pair (00, 01, 11) keeps it released.
- R4: The alarm condition holds for every `walk_thru`/`card_ok` pair while `alarm_clr`=0.
- R5: `alarm_clr`=1 moves the machine to bolted on the next edge from any condition, whatever the other inputs are.
- R6: `gate_locked` is 1 exactly in the bolted condition and 0 in both the released and the alarm conditions. It changes only at a clock edge.
- R7: The state code is 00 (bolted), 01 (released) or 10 (alarm). Code 11 is never held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| card_ok | input | 1 | Valid fare card presented |
| walk_thru | input | 1 | Passenger walking through the gate |
| alarm_clr | input | 1 | Staff alarm clear |
| gate_locked | output | 1 | 1 while the gate is bolted |

## Verification
The released and alarm conditions both show `gate_locked`=0, so the port alone cannot tell them apart. That difference is the hardest thing to observe. The bench tells them apart with a probe cycle: a walk without a card and with no alarm clear. A released gate bolts again on that cycle, and a gate in the alarm condition stays unbolted. Every entry in the transition table is reached the same way. The bench first sets up the source condition (alarm clear, then a card or a walk), then applies the input under test, checks the output, and runs the probe when the output is 0.

// File: rtl/turnstile_pkg.sv
package turnstile_pkg;
  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    GATE_BOLTED   = 2'b00,
    GATE_RELEASED = 2'b01,
    GATE_ALARM    = 2'b10
  } gate_state_e;
endpackage

// File: rtl/turn_rst_sync.sv
module turn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[i] <= 1'b0;
        end else begin
          if (i == 0) chain_q[i] <= 1'b1;
          else        chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/turn_next.sv
module turn_next
  import turnstile_pkg::*;
(
  input  gate_state_e cur_state,
  input  logic        card_ok,
  input  logic        walk_thru,
  input  logic        alarm_clr,
  output gate_state_e nxt_state
);
  always_comb begin
    nxt_state = GATE_BOLTED;
    if (!alarm_clr) begin
      case (cur_state)
        GATE_BOLTED: begin
          case ({walk_thru, card_ok})
            2'b01:   nxt_state = GATE_RELEASED;
            2'b10:   nxt_state = GATE_ALARM;
            default: nxt_state = GATE_BOLTED;
          endcase
        end
        GATE_RELEASED: begin
          if (walk_thru && !card_ok) nxt_state = GATE_BOLTED;
          else                       nxt_state = GATE_RELEASED;
        end
        GATE_ALARM: nxt_state = GATE_ALARM;
        default:    nxt_state = GATE_BOLTED;
      endcase
    end
  end
endmodule

// File: rtl/turn_out.sv
module turn_out
  import turnstile_pkg::*;
(
  input  gate_state_e cur_state,
  output logic        gate_locked
);
  logic [STATE_W-1:0] code;
  assign code        = cur_state;
  assign gate_locked = ~(code[1] | code[0]);
endmodule

// File: rtl/turnstile_ctrl.sv
module turnstile_ctrl
  import turnstile_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic card_ok,
  input  logic walk_thru,
  input  logic alarm_clr,
  output logic gate_locked
);
  logic        rst_q_n;
  gate_state_e state_q;
  gate_state_e state_d;
  logic        state_en;

  turn_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  turn_next u_next (
    .cur_state (state_q),
    .card_ok   (card_ok),
    .walk_thru (walk_thru),
    .alarm_clr (alarm_clr),
    .nxt_state (state_d)
  );

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= GATE_BOLTED;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  turn_out u_out (
    .cur_state   (state_q),
    .gate_locked (gate_locked)
  );
endmodule

// File: rtl/turnstile_ctrl_chk.sv
module turnstile_ctrl_chk
  import turnstile_pkg::*;
(
  input logic        clk,
  input logic        rst_q_n,
  input logic        card_ok,
  input logic        walk_thru,
  input logic        alarm_clr,
  input gate_state_e state_q,
  input logic        gate_locked
);
  // R2
  card_release_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == GATE_BOLTED && !alarm_clr && card_ok && !walk_thru) |=> state_q == GATE_RELEASED);

  // R2
  tailgate_alarm_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == GATE_BOLTED && !alarm_clr && !card_ok && walk_thru) |=> state_q == GATE_ALARM);

  // R3
  pass_relock_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == GATE_RELEASED && !alarm_clr && !card_ok && walk_thru) |=> state_q == GATE_BOLTED);

  // R4
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == GATE_ALARM && !alarm_clr) |=> state_q == GATE_ALARM);

  // R5
  alarm_clear_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    alarm_clr |=> state_q == GATE_BOLTED);

  // R6
  lock_follows_state_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    gate_locked == (state_q == GATE_BOLTED));

  // R7
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    state_q != gate_state_e'(2'b11));
endmodule

bind turnstile_ctrl turnstile_ctrl_chk u_chk (
  .clk         (clk),
  .rst_q_n     (rst_q_n),
  .card_ok     (card_ok),
  .walk_thru   (walk_thru),
  .alarm_clr   (alarm_clr),
  .state_q     (state_q),
  .gate_locked (gate_locked)
);

// File: tb/sim_turnstile_ctrl.sv
`timescale 1ns/1ps
module sim_turnstile_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic card_ok, walk_thru, alarm_clr;
  logic gate_locked;
  int   n_vec = 0;
  int   n_bad = 0;

  always #5 clk = ~clk;

  turnstile_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .card_ok(card_ok),
    .walk_thru(walk_thru), .alarm_clr(alarm_clr), .gate_locked(gate_locked)
  );

  // condition codes used only in the bench: 0 bolted, 1 released, 2 alarm
  task automatic check(input string req, input logic got, input logic exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, got, exp);
    end
  endtask

  // apply one input word for one clock, sample at the following negedge
  task automatic step(input logic a, input logic w, input logic c);
    @(negedge clk);
    alarm_clr = a; walk_thru = w; card_ok = c;
    @(posedge clk);
    @(negedge clk);
    alarm_clr = 1'b0; walk_thru = 1'b0; card_ok = 1'b0;
  endtask

  task automatic enter(input int cond);
    step(1'b1, 1'b0, 1'b0);
    if (cond == 1) step(1'b0, 1'b0, 1'b1);
    if (cond == 2) step(1'b0, 1'b1, 1'b0);
  endtask

  // verify the condition through the port; a walk without card bolts a released gate only
  task automatic expect_cond(input string req, input int cond);
    if (cond == 0) begin
      check(req, gate_locked, 1'b1);
    end else begin
      check(req, gate_locked, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      check(req, gate_locked, (cond == 1) ? 1'b1 : 1'b0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; card_ok = 1'b0; walk_thru = 1'b0; alarm_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", gate_locked, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", gate_locked, 1'b1);
  endtask

  task automatic t_bolted();
    for (int p = 0; p < 4; p++) begin
      int exp;
      exp = (p == 1) ? 1 : (p == 2) ? 2 : 0;
      enter(0);
      step(1'b0, p[1], p[0]);
      expect_cond("R2", exp);
    end
  endtask

  task automatic t_released();
    for (int p = 0; p < 4; p++) begin
      enter(1);
      step(1'b0, p[1], p[0]);
      expect_cond("R3", (p == 2) ? 0 : 1);
    end
  endtask

  task automatic t_alarm();
    for (int p = 0; p < 4; p++) begin
      enter(2);
      step(1'b0, p[1], p[0]);
      step(1'b0, p[1], p[0]);
      expect_cond("R4", 2);
    end
  endtask

  task automatic t_clear();
    for (int s = 0; s < 3; s++) begin
      for (int p = 0; p < 4; p++) begin
        enter(s);
        step(1'b1, p[1], p[0]);
        expect_cond("R5", 0);
      end
    end
  endtask

  task automatic t_output();
    // output follows the state only at clock edges
    enter(0);
    @(negedge clk);
    card_ok = 1'b1;
    #2;
    check("R6", gate_locked, 1'b1);
    @(posedge clk);
    #1;
    check("R6", gate_locked, 1'b0);
    card_ok = 1'b0;
    @(negedge clk);
    enter(2);
    check("R6", gate_locked, 1'b0);
    // R7: from any legal state, every pair lands on a decodable condition
    enter(2);
    step(1'b0, 1'b1, 1'b1);
    expect_cond("R7", 2);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_bolted();
    t_released();
    t_alarm();
    t_clear();
    t_output();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule